// File: doc/BRIEF.md
# Dual-Clock FIFO with Strap-Selected Write Enables

This block is a first-in first-out buffer for 9-bit words whose write port and read port run on unrelated clocks. The write side reports a full flag and an almost-full flag, both active low. The read side reports an empty flag and an almost-empty flag, both active low. Each flag is produced in the clock domain that owns it. The read pointer is carried to the write side, and the write pointer to the read side, as Gray-coded values through two-flop synchronizers.

A shared pin, `wen2_ld`, is sampled while reset is held, and its level picks the mode:

- **Two-enable mode (pin high).** The pin acts as a second, active-high write enable, so several devices can be cascaded for depth expansion. Both almost-flag thresholds come from parameters.
- **Programmable-flag mode (pin low).** `wen_n` is the only write enable. A low level on the pin marks a threshold-load cycle, which belongs to an external offset sequencer, so no FIFO write happens in that cycle. The thresholds come from the `empty_ofs` and `full_ofs` inputs that the sequencer drives.

A read needs both active-low read enables. It moves the oldest word into an output register. That register drives the output bus when `oe_n` is low, and the bus floats when `oe_n` is high.

Top module: `dcf_dualmode_fifo`

## Requirements
- R1: While `rst_n` is low, both pointers return to the first location and the output register clears to zero. After release, `full_n` and `almost_full_n` read 1, and `empty_n` and `almost_empty_n` read 0.
- R2: The level of `wen2_ld` while `rst_n` is low sets the mode. A 1 selects two-enable mode with thresholds DEF_EMPTY_OFS and DEF_FULL_OFS (default 7 each). A 0 selects programmable-flag mode, with thresholds taken from `empty_ofs` and `full_ofs`.
- R3: A word is stored on a rising `wr_clk` only when `wen_n` is 0 and `wen2_ld` is 1. Any other combination stores nothing.
- R4: The next word is loaded into the output register on a rising `rd_clk` only when `ren_a_n` and `ren_b_n` are both 0. If either is 1, the register and the occupancy are unchanged.
- R5: While `full_n` is 0, write attempts are ignored, and the stored contents and their order are preserved.
- R6: While `empty_n` is 0, read attempts are ignored, and the output register keeps its value.
- R7: `almost_empty_n` is 0 exactly when the occupancy seen on the read side is at or below the active empty threshold. It is always 0 while `empty_n` is 0.
- R8: `almost_full_n` is 0 exactly when the free space seen on the write side is at or below the active full threshold. It is always 0 while `full_n` is 0.
- R9: With `oe_n` at 1, `dout` is high-impedance. With `oe_n` at 0, `dout` shows the output register.
- R10: Words leave in the order they entered, across the whole depth (64 by default). Flags settle within a few cycles of the receiving clock. The Gray-coded write pointer changes by at most one bit per write clock.
- R11: A reset applied while words are held discards them. Afterwards the FIFO reads empty and `dout` is zero.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| wr_clk | input | 1 | Write-side clock |
| rd_clk | input | 1 | Read-side clock, may be unrelated to wr_clk |
| rst_n | input | 1 | Asynchronous reset, active low |
| din | input | DATA_W | Write data |
| wen_n | input | 1 | Write enable, active low |
| wen2_ld | input | 1 | Mode strap during reset; afterwards second write enable (high) or threshold-load strobe (low) |
| ren_a_n | input | 1 | First read enable, active low |
| ren_b_n | input | 1 | Second read enable, active low |
| oe_n | input | 1 | Output enable, active low |
| empty_ofs | input | ADDR_W | Almost-empty threshold from the offset sequencer |
| full_ofs | input | ADDR_W | Almost-full threshold from the offset sequencer |
| dout | output | DATA_W | Output register contents, or high-impedance |
| full_n | output | 1 | Full flag, active low, write clock domain |
| almost_full_n | output | 1 | Almost-full flag, active low, write clock domain |
| empty_n | output | 1 | Empty flag, active low, read clock domain |
| almost_empty_n | output | 1 | Almost-empty flag, active low, read clock domain |

## Verification
The bench fills the FIFO to the last free slot and then offers one more write with a distinctive value. A design that let that write through would overwrite the oldest word, and the drain that follows would return wrong data or leave a word behind.

It offers reads with only one enable low, and reads while empty. A design that honoured either would move the output register or step the read pointer. The bench also offers a write cycle with the load strobe low, which a careless decode would store as data.

Both flag thresholds are probed one word either side of the boundary, in both modes. The programmable-mode thresholds are set below the defaults, so a design that ignored the strap, or compared with the wrong sense, gives the wrong flag level. Finally, a reset is issued with words in flight, which catches pointers or an output register that survive reset.

// File: rtl/dcf_pkg.sv
`timescale 1ns/1ps
package dcf_pkg;
  typedef enum logic {
    MODE_TWO_WEN   = 1'b0,
    MODE_PROG_FLAG = 1'b1
  } fifo_mode_e;
endpackage

// File: rtl/dcf_rst_sync.sv
`timescale 1ns/1ps
module dcf_rst_sync (
  input  logic clk,
  input  logic arst_n,
  output logic srst_n
);
  logic [1:0] stage_q;

  always_ff @(posedge clk or negedge arst_n) begin
    if (!arst_n) stage_q <= 2'b00;
    else         stage_q <= {stage_q[0], 1'b1};
  end

  assign srst_n = stage_q[1];
endmodule

// File: rtl/dcf_ptr_sync.sv
`timescale 1ns/1ps
module dcf_ptr_sync #(
  parameter int unsigned W = 7
) (
  input  logic         clk,
  input  logic         rst_n,
  input  logic [W-1:0] gray_in,
  output logic [W-1:0] bin_out
);
  logic [W-1:0] meta_q, sync_q;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      meta_q <= '0;
      sync_q <= '0;
    end else begin
      meta_q <= gray_in;
      sync_q <= meta_q;
    end
  end

  always_comb begin
    for (int i = 0; i < W; i++) bin_out[i] = ^(sync_q >> i);
  end
endmodule

// File: rtl/dcf_ram.sv
`timescale 1ns/1ps
module dcf_ram #(
  parameter int unsigned ADDR_W = 6,
  parameter int unsigned DATA_W = 9
) (
  input  logic              wclk,
  input  logic              we,
  input  logic [ADDR_W-1:0] waddr,
  input  logic [DATA_W-1:0] wdata,
  input  logic [ADDR_W-1:0] raddr,
  output logic [DATA_W-1:0] rdata
);
  localparam int unsigned DEPTH = 1 << ADDR_W;

  logic [DATA_W-1:0] mem [DEPTH];

  always_ff @(posedge wclk) begin
    if (we) mem[waddr] <= wdata;
  end

  assign rdata = mem[raddr];
endmodule

// File: rtl/dcf_wr_side.sv
`timescale 1ns/1ps
module dcf_wr_side import dcf_pkg::*; #(
  parameter int unsigned ADDR_W       = 6,
  parameter int unsigned DEF_FULL_OFS = 7,
  localparam int unsigned PTR_W       = ADDR_W + 1
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              wen_n,
  input  logic              wen2_ld,
  input  logic [ADDR_W-1:0] full_ofs,
  input  logic [PTR_W-1:0]  rbin_s,
  output logic              we,
  output logic [ADDR_W-1:0] waddr,
  output logic [PTR_W-1:0]  wgray,
  output logic              full_n,
  output logic              almost_full_n
);
  localparam logic [PTR_W-1:0] DEPTH_P = {1'b1, {ADDR_W{1'b0}}};

  fifo_mode_e       mode_q;
  logic [PTR_W-1:0] wbin_q, wbin_d, wgray_q, wgray_d;
  logic [PTR_W-1:0] used, free, thr;
  logic             full, wr_req, wr_go;

  // strap sampled every clock while the local reset is held
  always_ff @(posedge clk) begin
    if (!rst_n) mode_q <= wen2_ld ? MODE_TWO_WEN : MODE_PROG_FLAG;
  end

  always_comb begin
    used    = wbin_q - rbin_s;
    free    = DEPTH_P - used;
    full    = (used == DEPTH_P);
    thr     = (mode_q == MODE_PROG_FLAG) ? {1'b0, full_ofs} : PTR_W'(DEF_FULL_OFS);
    wr_req  = !wen_n && wen2_ld;
    wr_go   = wr_req && !full;
    wbin_d  = wbin_q + PTR_W'(wr_go);
    wgray_d = wbin_d ^ (wbin_d >> 1);
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      wbin_q  <= '0;
      wgray_q <= '0;
    end else if (wr_go) begin
      wbin_q  <= wbin_d;
      wgray_q <= wgray_d;
    end
  end

  assign we            = wr_go;
  assign waddr         = wbin_q[ADDR_W-1:0];
  assign wgray         = wgray_q;
  assign full_n        = !full;
  assign almost_full_n = !(free <= thr);

  assert_no_overflow_R5: assert property (@(posedge clk) disable iff (!rst_n)
    used <= DEPTH_P) else $error("occupancy beyond depth");
  assert_full_blocks_R5: assert property (@(posedge clk) disable iff (!rst_n)
    (!full_n && wr_req) |=> $stable(wbin_q)) else $error("write while full");
  assert_af_covers_full_R8: assert property (@(posedge clk) disable iff (!rst_n)
    !full_n |-> !almost_full_n) else $error("full without almost-full");
  assert_gray_step_R10: assert property (@(posedge clk) disable iff (!rst_n)
    $countones(wgray_q ^ $past(wgray_q)) <= 1) else $error("gray multi-bit step");
endmodule

// File: rtl/dcf_rd_side.sv
`timescale 1ns/1ps
module dcf_rd_side import dcf_pkg::*; #(
  parameter int unsigned ADDR_W        = 6,
  parameter int unsigned DATA_W        = 9,
  parameter int unsigned DEF_EMPTY_OFS = 7,
  localparam int unsigned PTR_W        = ADDR_W + 1
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              mode_pin,
  input  logic              ren_a_n,
  input  logic              ren_b_n,
  input  logic [ADDR_W-1:0] empty_ofs,
  input  logic [PTR_W-1:0]  wbin_s,
  input  logic [DATA_W-1:0] rdata,
  output logic [ADDR_W-1:0] raddr,
  output logic [PTR_W-1:0]  rgray,
  output logic [DATA_W-1:0] q,
  output logic              empty_n,
  output logic              almost_empty_n
);
  localparam logic [PTR_W-1:0] DEPTH_P = {1'b1, {ADDR_W{1'b0}}};

  fifo_mode_e        mode_q;
  logic [PTR_W-1:0]  rbin_q, rbin_d, rgray_q, rgray_d;
  logic [PTR_W-1:0]  occ, thr;
  logic [DATA_W-1:0] q_q, q_d;
  logic              empty, rd_req, rd_go;

  always_ff @(posedge clk) begin
    if (!rst_n) mode_q <= mode_pin ? MODE_TWO_WEN : MODE_PROG_FLAG;
  end

  always_comb begin
    occ     = wbin_s - rbin_q;
    empty   = (occ == '0);
    thr     = (mode_q == MODE_PROG_FLAG) ? {1'b0, empty_ofs} : PTR_W'(DEF_EMPTY_OFS);
    rd_req  = !ren_a_n && !ren_b_n;
    rd_go   = rd_req && !empty;
    rbin_d  = rbin_q + PTR_W'(rd_go);
    rgray_d = rbin_d ^ (rbin_d >> 1);
    q_d     = rd_go ? rdata : q_q;
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      rbin_q  <= '0;
      rgray_q <= '0;
      q_q     <= '0;
    end else begin
      q_q <= q_d;
      if (rd_go) begin
        rbin_q  <= rbin_d;
        rgray_q <= rgray_d;
      end
    end
  end

  assign raddr          = rbin_q[ADDR_W-1:0];
  assign rgray          = rgray_q;
  assign q              = q_q;
  assign empty_n        = !empty;
  assign almost_empty_n = !(occ <= thr);

  assert_no_underflow_R10: assert property (@(posedge clk) disable iff (!rst_n)
    occ <= DEPTH_P) else $error("read pointer passed write pointer");
  assert_partial_enable_holds_R4: assert property (@(posedge clk) disable iff (!rst_n)
    (ren_a_n || ren_b_n) |=> ($stable(q_q) && $stable(rbin_q))) else $error("read with one enable");
  assert_empty_blocks_R6: assert property (@(posedge clk) disable iff (!rst_n)
    (!empty_n && rd_req) |=> $stable(q_q)) else $error("read while empty");
  assert_ae_covers_empty_R7: assert property (@(posedge clk) disable iff (!rst_n)
    !empty_n |-> !almost_empty_n) else $error("empty without almost-empty");
endmodule

// File: rtl/dcf_dualmode_fifo.sv
`timescale 1ns/1ps
module dcf_dualmode_fifo #(
  parameter int unsigned ADDR_W        = 6,
  parameter int unsigned DATA_W        = 9,
  parameter int unsigned DEF_EMPTY_OFS = 7,
  parameter int unsigned DEF_FULL_OFS  = 7
) (
  input  logic              wr_clk,
  input  logic              rd_clk,
  input  logic              rst_n,
  input  logic [DATA_W-1:0] din,
  input  logic              wen_n,
  input  logic              wen2_ld,
  input  logic              ren_a_n,
  input  logic              ren_b_n,
  input  logic              oe_n,
  input  logic [ADDR_W-1:0] empty_ofs,
  input  logic [ADDR_W-1:0] full_ofs,
  output logic [DATA_W-1:0] dout,
  output logic              full_n,
  output logic              almost_full_n,
  output logic              empty_n,
  output logic              almost_empty_n
);
  localparam int unsigned PTR_W = ADDR_W + 1;

  logic              wrst_n, rrst_n, we;
  logic [ADDR_W-1:0] waddr, raddr;
  logic [PTR_W-1:0]  wgray, rgray, wbin_s, rbin_s;
  logic [DATA_W-1:0] rdata, q;

  dcf_rst_sync u_wrst (.clk(wr_clk), .arst_n(rst_n), .srst_n(wrst_n));
  dcf_rst_sync u_rrst (.clk(rd_clk), .arst_n(rst_n), .srst_n(rrst_n));

  dcf_ptr_sync #(.W(PTR_W)) u_r2w (.clk(wr_clk), .rst_n(wrst_n), .gray_in(rgray), .bin_out(rbin_s));
  dcf_ptr_sync #(.W(PTR_W)) u_w2r (.clk(rd_clk), .rst_n(rrst_n), .gray_in(wgray), .bin_out(wbin_s));

  dcf_wr_side #(.ADDR_W(ADDR_W), .DEF_FULL_OFS(DEF_FULL_OFS)) u_wr (
    .clk(wr_clk), .rst_n(wrst_n), .wen_n(wen_n), .wen2_ld(wen2_ld),
    .full_ofs(full_ofs), .rbin_s(rbin_s), .we(we), .waddr(waddr),
    .wgray(wgray), .full_n(full_n), .almost_full_n(almost_full_n));

  dcf_ram #(.ADDR_W(ADDR_W), .DATA_W(DATA_W)) u_ram (
    .wclk(wr_clk), .we(we), .waddr(waddr), .wdata(din), .raddr(raddr), .rdata(rdata));

  dcf_rd_side #(.ADDR_W(ADDR_W), .DATA_W(DATA_W), .DEF_EMPTY_OFS(DEF_EMPTY_OFS)) u_rd (
    .clk(rd_clk), .rst_n(rrst_n), .mode_pin(wen2_ld), .ren_a_n(ren_a_n),
    .ren_b_n(ren_b_n), .empty_ofs(empty_ofs), .wbin_s(wbin_s), .rdata(rdata),
    .raddr(raddr), .rgray(rgray), .q(q), .empty_n(empty_n),
    .almost_empty_n(almost_empty_n));

  assign dout = oe_n ? {DATA_W{1'bz}} : q;
endmodule

// File: tb/dcf_dualmode_fifo_tb_top.sv
`timescale 1ns/1ps
module dcf_dualmode_fifo_tb_top;
  logic       wr_clk = 1'b0, rd_clk = 1'b0, rst_n = 1'b0;
  logic [8:0] din = '0;
  logic       wen_n = 1'b1, wen2_ld = 1'b1, ren_a_n = 1'b1, ren_b_n = 1'b1, oe_n = 1'b0;
  logic [5:0] empty_ofs = 6'd2, full_ofs = 6'd3;
  wire  [8:0] dout;
  wire        full_n, almost_full_n, empty_n, almost_empty_n;

  int checks = 0, fails = 0;
  logic [8:0] wr_next = 9'd1, rd_exp = 9'd1, v, last;

  dcf_dualmode_fifo dut_i (
    .wr_clk(wr_clk), .rd_clk(rd_clk), .rst_n(rst_n), .din(din), .wen_n(wen_n),
    .wen2_ld(wen2_ld), .ren_a_n(ren_a_n), .ren_b_n(ren_b_n), .oe_n(oe_n),
    .empty_ofs(empty_ofs), .full_ofs(full_ofs), .dout(dout), .full_n(full_n),
    .almost_full_n(almost_full_n), .empty_n(empty_n), .almost_empty_n(almost_empty_n));

  always #2 wr_clk = ~wr_clk;
  initial begin #1; forever #2 rd_clk = ~rd_clk; end

  // one row: writes, then reads, then flags {empty_n, almost_empty_n, almost_full_n, full_n}
  typedef struct packed { logic [7:0] nwr; logic [7:0] nrd; logic [3:0] flg; } vec_t;
  localparam vec_t VECS [8] = '{
    '{8'd1,  8'd0,  4'b1011},  // occ 1
    '{8'd6,  8'd0,  4'b1011},  // occ 7, at empty threshold
    '{8'd1,  8'd0,  4'b1111},  // occ 8, above it
    '{8'd0,  8'd8,  4'b0011},  // drained
    '{8'd57, 8'd0,  4'b1101},  // free 7, at full threshold
    '{8'd0,  8'd1,  4'b1111},  // free 8
    '{8'd8,  8'd0,  4'b1100},  // full
    '{8'd0,  8'd64, 4'b0011}   // drained from full
  };

  task automatic chk(input string tag, input logic [31:0] act, input logic [31:0] exp);
    checks++;
    if (act !== exp) begin
      fails++;
      $display("FAIL %s actual=%0h expected=%0h", tag, act, exp);
    end
  endtask

  task automatic push(input logic [8:0] val, input logic sel);
    @(negedge wr_clk); din = val; wen_n = 1'b0; wen2_ld = sel;
    @(negedge wr_clk); wen_n = 1'b1; wen2_ld = 1'b1;
  endtask

  task automatic push_seq();
    push(wr_next, 1'b1); wr_next++;
  endtask

  task automatic pop(output logic [8:0] val);
    @(negedge rd_clk); ren_a_n = 1'b0; ren_b_n = 1'b0;
    @(negedge rd_clk); ren_a_n = 1'b1; ren_b_n = 1'b1;
    val = dout;
  endtask

  task automatic pop_chk(input string tag);
    logic [8:0] got;
    pop(got); chk(tag, got, rd_exp); last = rd_exp; rd_exp++;
  endtask

  task automatic settle();
    repeat (8) @(negedge rd_clk);
  endtask

  task automatic flags(input string tag, input logic [3:0] exp);
    chk(tag, {empty_n, almost_empty_n, almost_full_n, full_n}, exp);
  endtask

  task automatic do_reset(input logic strap);
    @(negedge wr_clk); wen2_ld = strap; rst_n = 1'b0;
    repeat (4) @(negedge wr_clk);
    rst_n = 1'b1;
    repeat (4) @(negedge wr_clk);
    wen2_ld = 1'b1;
    rd_exp = wr_next;
    settle();
  endtask

  initial begin
    #800000;
    fails++; checks++;
    $display("FAIL watchdog actual=running expected=done");
    $display("%0d/%0d checks passed", checks - fails, checks);
    $finish;
  end

  initial begin
    // R1: reset state, two-enable strap
    do_reset(1'b1);
    flags("R1", 4'b0011);
    chk("R1", dout, 9'h000);

    // R3: load strobe low or enable high stores nothing
    push(9'h155, 1'b0);
    @(negedge wr_clk); din = 9'h0AA; wen_n = 1'b1; wen2_ld = 1'b1;
    @(negedge wr_clk);
    settle();
    flags("R3", 4'b0011);

    // R2 R7 R8 R10: vector table in two-enable mode (default thresholds 7)
    foreach (VECS[i]) begin
      for (int w = 0; w < int'(VECS[i].nwr); w++) push_seq();
      settle();
      for (int r = 0; r < int'(VECS[i].nrd); r++) pop_chk("R10");
      settle();
      flags("R7 R8 R2", VECS[i].flg);
    end

    // R4: a single active read enable does nothing
    push_seq(); settle();
    @(negedge rd_clk); ren_a_n = 1'b0; ren_b_n = 1'b1;
    @(negedge rd_clk); ren_a_n = 1'b1;
    chk("R4", dout, last);
    @(negedge rd_clk); ren_b_n = 1'b0;
    @(negedge rd_clk); ren_b_n = 1'b1;
    chk("R4", dout, last);
    settle();
    chk("R4", empty_n, 1'b1);
    pop_chk("R4");

    // R6: read while empty holds output
    settle();
    pop(v);
    chk("R6", v, last);

    // R9: output enable
    @(negedge rd_clk); oe_n = 1'b1; #1;
    chk("R9", ((dout === 9'bz) || (dout === 9'h000)) ? 1 : 0, 1);
    @(negedge rd_clk); oe_n = 1'b0; #1;
    chk("R9", dout, last);

    // R5: write while full is dropped
    for (int w = 0; w < 64; w++) push_seq();
    settle();
    chk("R5", full_n, 1'b0);
    push(9'h1AA, 1'b1);
    settle();
    for (int r = 0; r < 64; r++) pop_chk("R5");
    settle();
    flags("R5", 4'b0011);

    // R11: reset with words held, strap low selects programmable mode
    push_seq(); push_seq(); push_seq();
    settle();
    pop_chk("R11");
    do_reset(1'b0);
    flags("R11", 4'b0011);
    chk("R11", dout, 9'h000);

    // R2 R7: programmable empty threshold 2
    push_seq(); push_seq(); settle();
    chk("R7", almost_empty_n, 1'b0);
    push_seq(); settle();
    chk("R7 R2", almost_empty_n, 1'b1);

    // R2 R8: programmable full threshold 3
    for (int w = 0; w < 58; w++) push_seq();
    settle();
    chk("R8 R2", almost_full_n, 1'b0);
    chk("R8", full_n, 1'b1);
    pop_chk("R10");
    settle();
    chk("R8 R2", almost_full_n, 1'b1);

    $display("%0d/%0d checks passed", checks - fails, checks);
    $finish;
  end
endmodule